// File: doc/BRIEF.md
# Data-Clock-Aligned Sample Latch Timer

This block sits in the fast conversion-clock domain of a multi-rate converter and generates the enable that captures each incoming parallel sample word and feeds it to the interpolation chain. With no external alignment it runs as a plain divider. One latch fires every N conversion-clock edges. N is the interpolation factor, and software picks 2, 4 or 8.

When external alignment is allowed, a slower data clock drives the block from outside. The block samples that clock in its own domain and finds its rising edges. Each rising edge forces a latch at a fixed position and restarts the divider from it. Several devices that share one data clock therefore capture their inputs on the same conversion-clock edge. A one-cycle flag marks each sync edge that moved the divider away from the phase it would have reached anyway.

Top module: `dcs_latch_timing`

## Requirements
- R1: A synchronous active-high reset `rst` clears `dataOut`, `latchStrobe` and `realignPulse` to 0 and puts the divider at phase zero. If no sync event occurs, the first latch then happens on the N-th rising clock edge after reset is released.
- R2: `interpSel` encodes N as follows: 0 gives 2, 1 gives 4, 2 gives 8, and 3 also gives 8.
- R3: With no sync event, a latch happens on every N-th clock edge. On a latch edge `dataOut` takes the value `dataIn` has at that edge, and `latchStrobe` is high for exactly the following cycle. At every other edge `dataOut` keeps its value.
- R4: External alignment is active only when `extSyncEn`, `pllOff` and `twoPortMode` are all 1.
- R5: While external alignment is active, suppose a rising edge of `dataClkIn` is first seen at clock edge E0, meaning it was low at the edge before. A latch then happens at edge E2, the third edge counting E0. The divider restarts from that latch, so the next free-running latch follows N edges later. A rise that misses the setup time of an edge is seen one edge later, so its latch also moves one edge later.
- R6: When external alignment is not active, `dataClkIn` has no effect on `latchStrobe`, `dataOut` or `realignPulse`.
- R7: A new `interpSel` value is sampled only on a latch edge, whether the latch came from a wrap or a sync event. The spacing that is already running is never cut short or stretched.
- R8: `realignPulse` is high for one cycle, together with `latchStrobe`, when a sync event falls on an edge where the divider would not have wrapped. It stays low when the sync event matches the natural wrap.
- R9: Only a low-to-high change of `dataClkIn` makes a sync event. If the data clock stops at either level, the divider keeps latching every N edges from its last phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dataClkIn | input | 1 | External data clock, asynchronous to `clk` |
| extSyncEn | input | 1 | Configuration bit that requests external alignment |
| pllOff | input | 1 | High when the clock multiplier is bypassed |
| twoPortMode | input | 1 | High when two-port data mode is active |
| interpSel | input | 2 | Interpolation factor select (see R2) |
| dataIn | input | DATA_W | Parallel sample word |
| dataOut | output | DATA_W | Sample word captured on the latest latch edge |
| latchStrobe | output | 1 | High for the cycle after each latch edge |
| realignPulse | output | 1 | One-cycle flag that a sync event moved the divider phase |

## Verification
The bench targets the exact edge on which a data-clock rise forces a latch. A design with one synchronizer stage too many or too few puts the latch one edge late or early, and every aligned device then captures shifted data. It changes `interpSel` in the middle of a period, where a design that loads the new factor at once gives a short or runt spacing. It holds the data clock high and then stops it, where a level-sensitive design would keep re-syncing or stall. It also drives the data clock while one of the three enable conditions is low, where a gating fault lets the clock move the phase.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic latchEn;
    logic realign;
  } latchCtrl_t;

  // interpolation select to last divider phase (factor - 1)
  function automatic logic [2:0] selToLast(input logic [1:0] sel);
    case (sel)
      2'd0:    return 3'd1;
      2'd1:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/dcs_latch_ctrl.sv
module dcs_latch_ctrl
  import dcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dataClkIn,
  input  logic       extActive,
  input  logic [1:0] interpSel,
  output latchCtrl_t ctrl
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLvl;
  logic [2:0]             phase;
  logic [2:0]             lastPhase;
  logic                   syncEdge;
  logic                   wrapNow;

  assign syncEdge = extActive && syncChain[SYNC_STAGES-1] && !prevLvl;
  assign wrapNow  = (phase == lastPhase);

  always_comb begin
    ctrl.latchEn = syncEdge || wrapNow;
    ctrl.realign = syncEdge && !wrapNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      syncChain <= '0;
      prevLvl   <= 1'b0;
      phase     <= '0;
      lastPhase <= selToLast(interpSel);
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], dataClkIn};
      prevLvl   <= syncChain[SYNC_STAGES-1];
      if (ctrl.latchEn) begin
        phase     <= '0;
        lastPhase <= selToLast(interpSel);
      end else begin
        phase <= phase + 3'd1;
      end
    end
  end

  // R1 / R3: divider never passes its last phase
  a_r3_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    phase <= lastPhase);

  // R5: a sync event restarts the divider
  a_r5_sync_restarts: assert property (@(posedge clk) disable iff (rst)
    syncEdge |=> (phase == 3'd0));

  // R7: factor only changes on a latch edge
  a_r7_ratio_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.latchEn |=> $stable(lastPhase));

  // R6: without alignment the divider simply counts
  a_r6_free_count: assert property (@(posedge clk) disable iff (rst)
    (!extActive && !wrapNow) |=> (phase == $past(phase) + 3'd1));
endmodule

// File: rtl/dcs_latch_path.sv
module dcs_latch_path
  import dcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  latchCtrl_t        ctrl,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              latchStrobe,
  output logic              realignPulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut      <= '0;
      latchStrobe  <= 1'b0;
      realignPulse <= 1'b0;
    end else begin
      latchStrobe  <= ctrl.latchEn;
      realignPulse <= ctrl.realign;
      if (ctrl.latchEn) dataOut <= dataIn;
    end
  end

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!latchStrobe && !realignPulse && dataOut == '0));

  // R3: data holds between latches
  a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.latchEn |=> $stable(dataOut));

  // R8: realign flag only accompanies a strobe
  a_r8_realign_with_strobe: assert property (@(posedge clk) disable iff (rst)
    realignPulse |-> latchStrobe);
endmodule

// File: rtl/dcs_latch_timing.sv
module dcs_latch_timing
  import dcs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dataClkIn,
  input  logic              extSyncEn,
  input  logic              pllOff,
  input  logic              twoPortMode,
  input  logic [1:0]        interpSel,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              latchStrobe,
  output logic              realignPulse
);
  latchCtrl_t ctrl;
  logic       extActive;

  assign extActive = extSyncEn && pllOff && twoPortMode;

  dcs_latch_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dataClkIn (dataClkIn),
    .extActive (extActive),
    .interpSel (interpSel),
    .ctrl      (ctrl)
  );

  dcs_latch_path #(.DATA_W(DATA_W)) u_path (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .dataIn       (dataIn),
    .dataOut      (dataOut),
    .latchStrobe  (latchStrobe),
    .realignPulse (realignPulse)
  );
endmodule

// File: tb/dcs_latch_timing_bench.sv
`timescale 1ns/1ps
module dcs_latch_timing_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dataClkIn = 1'b0;
  logic         extSyncEn = 1'b0;
  logic         pllOff = 1'b0;
  logic         twoPortMode = 1'b0;
  logic [1:0]   interpSel = 2'd1;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut;
  logic         latchStrobe;
  logic         realignPulse;

  dcs_latch_timing #(.DATA_W(W)) u_dcs_latch_timing (
    .clk(clk), .rst(rst), .dataClkIn(dataClkIn), .extSyncEn(extSyncEn),
    .pllOff(pllOff), .twoPortMode(twoPortMode), .interpSel(interpSel),
    .dataIn(dataIn), .dataOut(dataOut), .latchStrobe(latchStrobe),
    .realignPulse(realignPulse)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // reference state, derived from the requirements
  int           mCnt = 0;
  int           mN = 4;
  logic         lv1 = 0, lv2 = 0, lv3 = 0;
  logic [W-1:0] mData = '0;
  logic         mStb = 0, mRe = 0;

  function automatic int factorOf(input logic [1:0] s);
    return (s == 2'd0) ? 2 : (s == 2'd1) ? 4 : 8;
  endfunction

  task automatic check1(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", curReq, what, act, exp);
    end
  endtask

  // one clock edge: predict, clock, compare
  task automatic tick();
    logic ev;
    logic act;
    act = extSyncEn && pllOff && twoPortMode;
    if (rst) begin
      mCnt = 0; mN = factorOf(interpSel);
      lv1 = 0; lv2 = 0; lv3 = 0;
      mData = '0; mStb = 0; mRe = 0;
    end else begin
      ev   = act && lv2 && !lv3;
      mStb = ev || (mCnt == mN - 1);
      mRe  = ev && (mCnt != mN - 1);
      if (mStb) begin
        mCnt = 0; mN = factorOf(interpSel); mData = dataIn;
      end else begin
        mCnt++;
      end
      lv3 = lv2; lv2 = lv1; lv1 = dataClkIn;
    end
    @(posedge clk);
    #2;
    check1("latchStrobe", latchStrobe, mStb);
    check1("realignPulse", realignPulse, mRe);
    checks++;
    if (dataOut !== mData) begin
      errors++;
      $display("FAIL %s dataOut: actual %h expected %h", curReq, dataOut, mData);
    end
    dataIn = W'($urandom);
  endtask

  task automatic doReset(input logic [1:0] sel);
    rst = 1'b1; interpSel = sel;
    tick(); tick();
    rst = 1'b0;
  endtask

  // square data clock of period n edges, rising every n ticks after an offset
  task automatic runDataClk(input int n, input int offs, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      dataClkIn = (((i + offs) % n) < n / 2);
      tick();
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state and first latch position
    curReq = "R1";
    doReset(2'd1);
    for (int i = 0; i < 12; i++) tick();
    // R2 / R3: each factor, free running
    for (int s = 0; s < 4; s++) begin
      curReq = (s == 3) ? "R2" : "R3";
      doReset(2'(s));
      for (int i = 0; i < 20; i++) tick();
    end
    // R7: change factor mid-period
    curReq = "R7";
    doReset(2'd2);
    for (int i = 0; i < 11; i++) tick();
    interpSel = 2'd0;
    for (int i = 0; i < 12; i++) tick();
    interpSel = 2'd2;
    tick();
    for (int i = 0; i < 20; i++) tick();
    // R5 / R8: aligned data clock at several offsets
    extSyncEn = 1; pllOff = 1; twoPortMode = 1;
    for (int o = 0; o < 8; o++) begin
      curReq = (o % 2 == 0) ? "R5" : "R8";
      doReset(2'd2);
      dataClkIn = 0;
      runDataClk(8, o + 1, 40);
    end
    // R9: data clock held high, then stopped low
    curReq = "R9";
    doReset(2'd1);
    for (int i = 0; i < 3; i++) tick();
    dataClkIn = 1;
    for (int i = 0; i < 25; i++) tick();
    dataClkIn = 0;
    for (int i = 0; i < 25; i++) tick();
    // R4 / R6: one enable condition low, data clock ignored
    for (int g = 0; g < 3; g++) begin
      curReq = (g == 0) ? "R4" : "R6";
      extSyncEn = (g != 0); pllOff = (g != 1); twoPortMode = (g != 2);
      doReset(2'd1);
      runDataClk(3, g, 30);
    end
    // random mix
    curReq = "R5";
    doReset(2'd0);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) interpSel = 2'($urandom);
      if ($urandom_range(0, 3) == 0) dataClkIn = ~dataClkIn;
      if ($urandom_range(0, 49) == 0) begin
        extSyncEn = 1'($urandom); pllOff = 1'($urandom); twoPortMode = 1'($urandom);
      end
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule